// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is a behavioural model of a parallel NOR flash device, meant for simulation and FPGA prototypes. It sits on a simple synchronous bus with address, write data, an access-size code, a write strobe and a read strobe. Writes are read as command bytes taken from the low data byte, or as data, depending on the command in progress. Commands can span up to four write cycles. A command register and a write-cycle counter track where the device is in a sequence.

Program, block erase and buffered program act on an internal byte array. This array is a register memory whose sectors are a power of two in length. An 8-bit status register gathers sticky result bits. A read returns array data, the status byte or an identifier, depending on the command that is latched. A read-only configuration input blocks every change to the array and reports the blocked operation in status. A byte-order selector picks little-endian (default) or big-endian packing for 2-byte and 4-byte accesses.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the device is in array-read mode with the write-cycle counter at 0. The status register reads 0x80 and every array byte reads 0xFF.
- R2: A cycle-0 write of 0xFF, 0xF0 or 0x00 returns the device to array-read mode. A cycle-0 write of 0x50 clears status to 0x00 and also returns it to array-read mode.
- R3: A cycle-0 write of 0x70 (status) or 0x90 (identifier) latches that command and leaves the cycle counter at 0, so the next write is decoded as a new command.
- R4: A cycle-0 write of 0x20 fills the whole sector that holds the address with 0xFF, sets status bit 7 and moves to cycle 1. In cycle 1, 0xD0 returns to cycle 0 and sets bit 7. Any other byte, 0xFF included, returns to array-read mode.
- R5: After a cycle-0 write of 0x10 or 0x40, the next write stores its data at its address with its access size. It then sets status bit 7 and returns to cycle 0.
- R6: While read_only is high, the array never changes. An erase sets status bit 5 and a program sets status bit 4, and bit 7 is set as usual.
- R7: After a cycle-0 write of 0x60, a second byte of 0xD0 or 0x01 sets status bit 7 and returns to cycle 0. Any other byte returns to array-read mode.
- R8: Buffered program runs as follows. 0xE8 sets bit 7. The next write gives a count, masked to the device width in bytes. Each following write stores data, and the write made while the count is 0 is the last one. Then 0xD0 finishes the operation and sets bit 7, and any other byte aborts to array-read mode.
- R9: A cycle-0 byte that is not a known command, such as 0x98 or 0x33, forces array-read mode.
- R10: acc_size 0/1/2-3 selects 1/2/4 bytes at consecutive addresses. With big_endian low, byte k of the access is data bits [8k+7:8k]. With big_endian high, the order is reversed.
- R11: While the latched command is 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8, a read returns the status byte in every byte lane of the access and zero in the other lanes.
- R12: While 0x90 is latched, a read at address 0 returns the manufacturer code and a read at address 1 returns the part code, each zero-extended. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data; command byte in bits [7:0] |
| acc_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| read_only | input | 1 | Write-protect configuration |
| big_endian | input | 1 | Byte-order selector for multi-byte accesses |
| rdata | output | 32 | Read data, registered |

## Verification
A write changes the command, cycle counter, status and array at the clock edge that samples wr_en. A read strobed at that same edge still sees the state from before the write. Read data is registered: it appears on rdata after the edge that samples rd_en and holds until the next read. The bench therefore drives each strobe on a falling edge and samples rdata on the falling edge after the capturing rising edge. A behavioural reference model in the bench steps through the same edges and is compared against rdata on every falling edge. Explicit reads with values worked out by hand cover each command sequence, and a final sweep reads every array byte.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam logic [7:0] OP_ARRAY    = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLRST    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_BUFPRG   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_RESET    = 8'hFF;
  localparam logic [7:0] OP_RESET_B  = 8'hF0;

  localparam logic [7:0] ST_READY    = 8'h80;
  localparam logic [7:0] ST_ERASE_ER = 8'h20;
  localparam logic [7:0] ST_PROG_ER  = 8'h10;

  // access-size code to byte count
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bus lane that holds access byte k
  function automatic logic [1:0] lane_pos(input logic [2:0] n, input logic [1:0] k,
                                          input logic be);
    return be ? 2'(n - 3'd1 - {1'b0, k}) : k;
  endfunction

  function automatic logic reads_status(input logic [7:0] cmd);
    return (cmd == OP_PROG_A) || (cmd == OP_PROG_B) || (cmd == OP_ERASE) ||
           (cmd == OP_CLRST) || (cmd == OP_LOCK) || (cmd == OP_STATUS) ||
           (cmd == OP_BUFPRG);
  endfunction
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int DEV_BYTES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        read_only,
  output logic [7:0]  cmd_q,
  output logic [1:0]  cyc_q,
  output logic [7:0]  status_q,
  output logic        prog_en,
  output logic        erase_en
);
  localparam int CNT_W = 8 * DEV_BYTES;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0] cmd_n, status_n;
  logic [1:0] cyc_n;
  logic [7:0] op;
  logic       evt_unknown;
  logic       evt_last_buf;

  assign op = wdata[7:0];
  assign evt_unknown = wr_en && (cyc_q == 2'd0) &&
    !(op inside {OP_ARRAY, OP_RESET, OP_RESET_B, OP_CLRST, OP_STATUS, OP_IDENT,
                 OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_BUFPRG});
  assign evt_last_buf = wr_en && (cyc_q == 2'd2) && (cmd_q == OP_BUFPRG) &&
                        (cnt_q == '0);

  always_comb begin
    cmd_n    = cmd_q;
    cyc_n    = cyc_q;
    status_n = status_q;
    cnt_n    = cnt_q;
    prog_en  = 1'b0;
    erase_en = 1'b0;
    if (wr_en) begin
      case (cyc_q)
        2'd0: begin
          case (op)
            OP_STATUS, OP_IDENT: cmd_n = op;
            OP_CLRST: begin status_n = '0; cmd_n = OP_ARRAY; end
            OP_PROG_A, OP_PROG_B, OP_LOCK: begin cmd_n = op; cyc_n = 2'd1; end
            OP_ERASE: begin
              if (read_only) status_n = status_n | ST_ERASE_ER;
              else erase_en = 1'b1;
              status_n = status_n | ST_READY;
              cmd_n = op; cyc_n = 2'd1;
            end
            OP_BUFPRG: begin
              status_n = status_n | ST_READY;
              cmd_n = op; cyc_n = 2'd1;
            end
            default: cmd_n = OP_ARRAY; // reset codes and unknown bytes
          endcase
        end
        2'd1: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              if (read_only) status_n = status_n | ST_PROG_ER;
              else prog_en = 1'b1;
              status_n = status_n | ST_READY;
              cyc_n = 2'd0;
            end
            OP_ERASE: begin
              cyc_n = 2'd0;
              if (op == OP_CONFIRM) status_n = status_n | ST_READY;
              else cmd_n = OP_ARRAY;
            end
            OP_LOCK: begin
              cyc_n = 2'd0;
              if (op == OP_CONFIRM || op == OP_LOCK_ALT) status_n = status_n | ST_READY;
              else cmd_n = OP_ARRAY;
            end
            OP_BUFPRG: begin cnt_n = wdata[CNT_W-1:0]; cyc_n = 2'd2; end
            default: begin cmd_n = OP_ARRAY; cyc_n = 2'd0; end
          endcase
        end
        2'd2: begin
          if (cmd_q == OP_BUFPRG) begin
            if (read_only) status_n = status_n | ST_PROG_ER;
            else prog_en = 1'b1;
            status_n = status_n | ST_READY;
            if (cnt_q == '0) begin
              cyc_n = 2'd3;
              if (read_only) status_n = status_n | ST_PROG_ER;
            end
            cnt_n = cnt_q - 1'b1;
          end else begin
            cmd_n = OP_ARRAY; cyc_n = 2'd0;
          end
        end
        default: begin
          cyc_n = 2'd0;
          if (cmd_q == OP_BUFPRG && op == OP_CONFIRM) status_n = status_n | ST_READY;
          else cmd_n = OP_ARRAY;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= OP_ARRAY;
      cyc_q    <= 2'd0;
      status_q <= ST_READY;
      cnt_q    <= '0;
    end else begin
      cmd_q    <= cmd_n;
      cyc_q    <= cyc_n;
      status_q <= status_n;
      cnt_q    <= cnt_n;
    end
  end

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cyc_q == 2'd0 && op == OP_CLRST |=> status_q == 8'h00 && cmd_q == OP_ARRAY); // R2
  AST_LATCH_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cyc_q == 2'd0 && (op == OP_STATUS || op == OP_IDENT) |=> cyc_q == 2'd0 && cmd_q == $past(op)); // R3
  AST_ERASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cyc_q == 2'd0 && op == OP_ERASE |=> status_q[7] && cyc_q == 2'd1); // R4
  AST_PROG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cyc_q == 2'd1 && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B) |=> cyc_q == 2'd0 && status_q[7]); // R5
  AST_BUF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last_buf |=> cyc_q == 2'd3); // R8
  AST_UNKNOWN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_unknown |=> cmd_q == OP_ARRAY && cyc_q == 2'd0); // R9
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array
  import nor_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int SECTOR_BYTES = 64,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int SW = $clog2(SECTOR_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [2:0]    nbytes,
  input  logic          be,
  input  logic          prog_en,
  input  logic          erase_en,
  input  logic          read_only,
  output logic [31:0]   rd_word
);
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      if (erase_en) begin
        for (int i = 0; i < MEM_BYTES; i++)
          if ((AW'(i) >> SW) == (addr >> SW)) mem[i] <= 8'hFF;
      end
      if (prog_en) begin
        for (int k = 0; k < 4; k++)
          if (3'(k) < nbytes)
            mem[addr + AW'(k)] <= wdata[8*lane_pos(nbytes, 2'(k), be) +: 8];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < nbytes)
        rd_word[8*lane_pos(nbytes, 2'(k), be) +: 8] = mem[addr + AW'(k)];
  end

  AST_RO_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    read_only |-> !(prog_en || erase_en)); // R6
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_pkg::*;
#(
  parameter int          MEM_BYTES    = 256,
  parameter int          SECTOR_BYTES = 64,
  parameter int          DEV_BYTES    = 1,
  parameter logic [7:0]  MFR_CODE     = 8'h5A,
  parameter logic [7:0]  PART_CODE    = 8'hC3,
  localparam int         AW           = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [1:0]    acc_size,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          read_only,
  input  logic          big_endian,
  output logic [31:0]   rdata
);
  logic [7:0]  cmd_q, status_q;
  logic [1:0]  cyc_q;
  logic        prog_en, erase_en;
  logic [2:0]  nbytes;
  logic [31:0] arr_word, rd_next;

  assign nbytes = size_bytes(acc_size);

  nor_cmd_fsm #(.DEV_BYTES(DEV_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .read_only(read_only),
    .cmd_q(cmd_q), .cyc_q(cyc_q), .status_q(status_q),
    .prog_en(prog_en), .erase_en(erase_en)
  );

  nor_byte_array #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .nbytes(nbytes),
    .be(big_endian), .prog_en(prog_en), .erase_en(erase_en),
    .read_only(read_only), .rd_word(arr_word)
  );

  always_comb begin
    rd_next = '0;
    if (reads_status(cmd_q)) begin
      for (int k = 0; k < 4; k++)
        if (3'(k) < nbytes) rd_next[8*k +: 8] = status_q;
    end else if (cmd_q == OP_IDENT) begin
      if (addr == AW'(0))      rd_next = {24'h0, MFR_CODE};
      else if (addr == AW'(1)) rd_next = {24'h0, PART_CODE};
    end else begin
      rd_next = arr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R11
  AST_CYCLE_ZERO_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == OP_STATUS || cmd_q == OP_IDENT) |-> cyc_q == 2'd0); // R3
endmodule

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;
  localparam int MEM = 256;
  localparam int SECT = 64;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] PART = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] acc_size = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, read_only = 1'b0, big_endian = 1'b0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nor_cmd_seq #(.MEM_BYTES(MEM), .SECTOR_BYTES(SECT), .DEV_BYTES(1),
                .MFR_CODE(MFR), .PART_CODE(PART)) u_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .acc_size(acc_size),
    .wr_en(wr_en), .rd_en(rd_en), .read_only(read_only), .big_endian(big_endian),
    .rdata(rdata)
  );

  // ---------------- reference model ----------------
  logic [7:0] ref_mem [MEM];
  logic [7:0] ref_cmd, ref_st;
  int ref_cyc;
  int ref_cnt;
  logic [31:0] exp_rd;

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit status_like(input logic [7:0] c);
    return c == 8'h10 || c == 8'h20 || c == 8'h40 || c == 8'h50 ||
           c == 8'h60 || c == 8'h70 || c == 8'hE8;
  endfunction

  function automatic logic [31:0] model_read(input int a, input int n);
    logic [31:0] w = 0;
    if (status_like(ref_cmd)) begin
      for (int k = 0; k < n; k++) w = w | (32'(ref_st) << (8 * k));
    end else if (ref_cmd == 8'h90) begin
      w = (a == 0) ? 32'(MFR) : (a == 1) ? 32'(PART) : 32'h0;
    end else begin
      for (int k = 0; k < n; k++) begin
        int sh = big_endian ? (n - 1 - k) : k;
        w = w | (32'(ref_mem[(a + k) % MEM]) << (8 * sh));
      end
    end
    return w;
  endfunction

  task automatic model_store(input int a, input logic [31:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      int sh = big_endian ? (n - 1 - k) : k;
      ref_mem[(a + k) % MEM] = 8'(d >> (8 * sh));
    end
  endtask

  task automatic to_array();
    ref_cmd = 8'h00;
    ref_cyc = 0;
  endtask

  task automatic model_write(input int a, input logic [31:0] d, input int n);
    logic [7:0] op = d[7:0];
    case (ref_cyc)
      0: begin
        if (op == 8'h00 || op == 8'hFF || op == 8'hF0) to_array();
        else if (op == 8'h50) begin ref_st = 0; to_array(); end
        else if (op == 8'h70 || op == 8'h90) ref_cmd = op;
        else if (op == 8'h10 || op == 8'h40 || op == 8'h60) begin ref_cmd = op; ref_cyc = 1; end
        else if (op == 8'h20) begin
          if (read_only) ref_st = ref_st | 8'h20;
          else for (int i = 0; i < MEM; i++) if (i / SECT == a / SECT) ref_mem[i] = 8'hFF;
          ref_st = ref_st | 8'h80; ref_cmd = op; ref_cyc = 1;
        end
        else if (op == 8'hE8) begin ref_st = ref_st | 8'h80; ref_cmd = op; ref_cyc = 1; end
        else to_array();
      end
      1: begin
        if (ref_cmd == 8'h10 || ref_cmd == 8'h40) begin
          if (read_only) ref_st = ref_st | 8'h10; else model_store(a, d, n);
          ref_st = ref_st | 8'h80; ref_cyc = 0;
        end else if (ref_cmd == 8'h20) begin
          if (op == 8'hD0) begin ref_cyc = 0; ref_st = ref_st | 8'h80; end else to_array();
        end else if (ref_cmd == 8'h60) begin
          if (op == 8'hD0 || op == 8'h01) begin ref_cyc = 0; ref_st = ref_st | 8'h80; end
          else to_array();
        end else if (ref_cmd == 8'hE8) begin
          ref_cnt = int'(d[7:0]); ref_cyc = 2;
        end else to_array();
      end
      2: begin
        if (read_only) ref_st = ref_st | 8'h10; else model_store(a, d, n);
        ref_st = ref_st | 8'h80;
        if (ref_cnt == 0) ref_cyc = 3;
        ref_cnt = (ref_cnt + 255) % 256;
      end
      default: begin
        if (op == 8'hD0) begin ref_cyc = 0; ref_st = ref_st | 8'h80; end else to_array();
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM; i++) ref_mem[i] = 8'hFF;
      ref_cmd = 8'h00; ref_st = 8'h80; ref_cyc = 0; ref_cnt = 0; exp_rd = 0;
    end else begin
      if (rd_en) exp_rd = model_read(int'(addr), nb(acc_size));
      if (wr_en) model_write(int'(addr), wdata, nb(acc_size));
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (status_like(ref_cmd)) check("R11 model compare", rdata, exp_rd);
      else if (ref_cmd == 8'h90) check("R12 model compare", rdata, exp_rd);
      else check("R10 model compare", rdata, exp_rd);
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [1:0] s);
    addr = 8'(a); wdata = d; acc_size = s; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [1:0] s, input logic [31:0] exp, input string tag);
    addr = 8'(a); acc_size = s; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(0, 2'd2, 32'hFFFF_FFFF, "R1 erased array after reset");
    wr(0, 32'h70, 2'd0);
    rd(0, 2'd2, 32'h8080_8080, "R1 status ready after reset (R11 4-lane)");
    rd(0, 2'd1, 32'h0000_8080, "R11 status in 2 lanes");

    // R5: program, little-endian
    wr(0, 32'h40, 2'd0);
    wr(32'h20, 32'hA1B2_C3D4, 2'd2);
    rd(0, 2'd0, 32'h0000_0080, "R11 status while program latched");
    wr(0, 32'hFF, 2'd0);
    rd(32'h20, 2'd2, 32'hA1B2_C3D4, "R5 programmed word");
    rd(32'h21, 2'd0, 32'h0000_00C3, "R10 little-endian byte 1");
    rd(32'h20, 2'd1, 32'h0000_C3D4, "R10 little-endian halfword");

    // R10: big-endian
    big_endian = 1'b1;
    rd(32'h20, 2'd2, 32'hD4C3_B2A1, "R10 big-endian word read");
    rd(32'h20, 2'd1, 32'h0000_D4C3, "R10 big-endian halfword read");
    wr(0, 32'h10, 2'd0);
    wr(32'h30, 32'h0000_1234, 2'd1);
    wr(0, 32'hFF, 2'd0);
    big_endian = 1'b0;
    rd(32'h30, 2'd1, 32'h0000_3412, "R10 big-endian store read back little");
    rd(32'h30, 2'd0, 32'h0000_0012, "R10 big-endian store first byte");

    // R4: block erase
    wr(0, 32'h10, 2'd0); wr(32'h50, 32'h77, 2'd0);
    wr(0, 32'h40, 2'd0); wr(32'h80, 32'h66, 2'd0);
    wr(0, 32'hFF, 2'd0);
    wr(32'h45, 32'h20, 2'd0);
    rd(0, 2'd0, 32'h0000_0080, "R4 status after erase command");
    wr(0, 32'hD0, 2'd0);
    wr(0, 32'h90, 2'd0);
    rd(0, 2'd0, 32'(MFR), "R4 confirm returns to cycle 0");
    wr(0, 32'hFF, 2'd0);
    rd(32'h50, 2'd0, 32'h0000_00FF, "R4 byte in erased sector");
    rd(32'h40, 2'd0, 32'h0000_00FF, "R4 sector start erased");
    rd(32'h7F, 2'd0, 32'h0000_00FF, "R4 sector end erased");
    rd(32'h80, 2'd0, 32'h0000_0066, "R4 next sector untouched");
    rd(32'h20, 2'd0, 32'h0000_00D4, "R4 previous sector untouched");
    wr(32'hC0, 32'h20, 2'd0); wr(0, 32'hFF, 2'd0);
    rd(32'hC0, 2'd0, 32'h0000_00FF, "R4 0xFF in cycle 1 gives array read");
    wr(32'hC0, 32'h20, 2'd0); wr(0, 32'h33, 2'd0);
    rd(32'hC1, 2'd0, 32'h0000_00FF, "R4 bad byte in cycle 1 gives array read");

    // R3 / R12: latch without advancing, identifier read
    wr(0, 32'h90, 2'd0); wr(0, 32'h70, 2'd0);
    rd(0, 2'd0, 32'h0000_0080, "R3 next write decoded as command");
    wr(0, 32'h90, 2'd0);
    rd(0, 2'd0, 32'(MFR), "R12 manufacturer code");
    rd(1, 2'd0, 32'(PART), "R12 part code");
    rd(2, 2'd0, 32'h0, "R12 other address");
    rd(0, 2'd1, 32'(MFR), "R12 zero-extended in 2-byte access");
    wr(0, 32'hFF, 2'd0);

    // R2: clear status and return codes
    wr(0, 32'h50, 2'd0);
    rd(32'h20, 2'd0, 32'h0000_00D4, "R2 clear status returns to array read");
    wr(0, 32'h70, 2'd0);
    rd(0, 2'd0, 32'h0, "R2 status cleared");
    wr(0, 32'hF0, 2'd0);
    rd(32'h20, 2'd0, 32'h0000_00D4, "R2 0xF0 returns to array read");
    wr(0, 32'h70, 2'd0); wr(0, 32'h00, 2'd0);
    rd(32'h20, 2'd0, 32'h0000_00D4, "R2 0x00 returns to array read");

    // R6: read-only
    read_only = 1'b1;
    wr(32'h80, 32'h20, 2'd0);
    rd(0, 2'd0, 32'h0000_00A0, "R6 erase blocked sets bit 5");
    wr(0, 32'hD0, 2'd0); wr(0, 32'hFF, 2'd0);
    rd(32'h80, 2'd0, 32'h0000_0066, "R6 array kept after erase");
    wr(0, 32'h10, 2'd0); wr(32'h80, 32'h11, 2'd0);
    rd(0, 2'd0, 32'h0000_00B0, "R6 program blocked sets bit 4");
    wr(0, 32'hFF, 2'd0);
    rd(32'h80, 2'd0, 32'h0000_0066, "R6 array kept after program");
    wr(0, 32'h50, 2'd0);
    read_only = 1'b0;

    // R7: lock sequences
    wr(0, 32'h60, 2'd0); wr(0, 32'hD0, 2'd0);
    rd(0, 2'd0, 32'h0000_0080, "R7 lock confirm sets ready");
    wr(0, 32'h90, 2'd0);
    rd(0, 2'd0, 32'(MFR), "R7 lock back in cycle 0");
    wr(0, 32'h60, 2'd0); wr(0, 32'h01, 2'd0);
    rd(0, 2'd0, 32'h0000_0080, "R7 alternate second byte");
    wr(0, 32'h60, 2'd0); wr(0, 32'h55, 2'd0);
    rd(32'h20, 2'd0, 32'h0000_00D4, "R7 bad second byte gives array read");

    // R8: buffered program
    wr(0, 32'hE8, 2'd0); wr(0, 32'h0000_0102, 2'd0);
    wr(32'h90, 32'hAA, 2'd0); wr(32'h91, 32'hBB, 2'd0); wr(32'h92, 32'hCC, 2'd0);
    wr(0, 32'hD0, 2'd0);
    rd(0, 2'd0, 32'h0000_0080, "R8 confirm sets ready");
    wr(0, 32'h90, 2'd0);
    rd(0, 2'd0, 32'(MFR), "R8 back in cycle 0");
    wr(0, 32'hFF, 2'd0);
    rd(32'h90, 2'd2, 32'hFFCC_BBAA, "R8 buffered bytes stored");
    wr(0, 32'hE8, 2'd0); wr(0, 32'h0000_0100, 2'd0);
    wr(32'hA0, 32'h5C, 2'd0); wr(32'hA1, 32'h77, 2'd0);
    rd(32'hA0, 2'd1, 32'h0000_FF5C, "R8 masked count and abort");

    // R9: unknown commands
    wr(0, 32'h98, 2'd0);
    rd(32'h20, 2'd0, 32'h0000_00D4, "R9 0x98 gives array read");
    wr(0, 32'h70, 2'd0); wr(0, 32'h33, 2'd0);
    rd(32'h20, 2'd0, 32'h0000_00D4, "R9 0x33 gives array read");

    // full sweep against the reference array
    for (int a = 0; a < MEM; a++) rd(a, 2'd0, 32'(ref_mem[a]), "R5 array sweep");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule